// File: doc/BRIEF.md
# Half-Rate Synchronous FIFO Write Port

This block moves bytes from an on-chip producer into an external bridge chip whose transmit FIFO is written synchronously. All logic runs on the clock that the external chip supplies. That clock may stop and restart at any moment, so the block has no lock or settle phase: it only advances when an edge arrives.

To relax output setup timing, a byte is placed on the data bus one full cycle before its write strobe. The strobe is active low. The bus then stays unchanged through the strobe cycle, so the external chip sees the data settled for two clock periods before it captures it. Writes can therefore occur at most on every other cycle, which gives a peak of one byte per two cycles (30 Mbyte/s at a 60 MHz device clock).

The external chip reports free space with an active-low flag. The block samples that flag in the cycle before it would strobe. While the flag is high, the block holds the pending byte on the bus and keeps waiting. The producer side uses a valid/ready handshake. Bus data and strobe both leave the block straight from flops.

Top module: `hrfw_half_rate_writer`

## Requirements
- R1: While reset is asserted and in the first cycle after it, wr_n is 1, in_ready is 1 and bus_data is 0.
- R2: wr_n is never low in two consecutive cycles.
- R3: In every cycle where wr_n is low, bus_data has the same value it had in the cycle before.
- R4: wr_n is low in a cycle only if space_n was low in the cycle before.
- R5: When a byte is waiting (wr_n = 1, in_ready = 0) and space_n is high, the next cycle keeps wr_n at 1, keeps in_ready at 0 and leaves bus_data unchanged.
- R6: in_ready is 1 exactly when no byte is waiting on the bus or the current cycle is a strobe cycle (wr_n = 0). It is 0 while a byte waits for its strobe.
- R7: Every byte accepted on the producer side (in_valid and in_ready both 1 at a rising edge) is strobed to the bus exactly once, in acceptance order.
- R8: With in_valid held at 1 and space_n held at 0, wr_n is low on exactly every other cycle.
- R9: While no byte is waiting (wr_n = 1 and in_ready = 1), wr_n stays high in the next cycle.
- R10: A byte accepted at an edge appears on bus_data in the next cycle with wr_n = 1. If space_n is low in that cycle, wr_n is low in the cycle after.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock supplied by the external chip; may stop at any time |
| rst | input | 1 | Synchronous reset, active high |
| in_data | input | DATA_W | Byte from the producer |
| in_valid | input | 1 | Producer has a byte |
| in_ready | output | 1 | Block takes the byte at this edge if in_valid is 1 |
| space_n | input | 1 | Active-low flag: external transmit FIFO has room |
| bus_data | output | DATA_W | Registered data bus toward the external chip |
| wr_n | output | 1 | Registered active-low write strobe |

## Verification
The assertions assume the producer follows valid/ready rules: once in_valid is high, in_data and in_valid stay put until a ready edge takes the byte. The bench keeps that rule by holding a refused byte and drawing a new one only after acceptance.

The assertions also assume space_n is synchronous to clk and settled before each edge. The bench drives space_n, in_valid and in_data only at falling edges.

The assertions relate the strobe to the previous cycle's flag and bus value, and take no account of how the external chip's own timing makes the flag move. The bench therefore varies space_n freely, including high flags at random while bytes wait.

// File: rtl/hrfw_pkg.sv
package hrfw_pkg;
  // Byte slot state: nothing held, byte held and waiting, strobe in flight
  typedef enum logic [1:0] {
    PH_EMPTY  = 2'd0,
    PH_SETUP  = 2'd1,
    PH_STROBE = 2'd2
  } ph_e;
endpackage

// File: rtl/hrfw_phase_ctl.sv
module hrfw_phase_ctl
  import hrfw_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic src_valid,
  input  logic space_n,
  output logic src_ready,
  output logic take,
  output logic fire
);
  ph_e ph_q, ph_d;

  always_comb begin
    // a slot is free when empty or when its byte leaves at this edge
    src_ready = (ph_q == PH_EMPTY) || (ph_q == PH_STROBE);
    take      = src_valid && src_ready;
    // strobe the next cycle only when a byte waits and the far side has room
    fire      = (ph_q == PH_SETUP) && !space_n;
    ph_d      = ph_q;
    unique case (ph_q)
      PH_EMPTY:  if (take) ph_d = PH_SETUP;
      PH_SETUP:  if (fire) ph_d = PH_STROBE;
      PH_STROBE: ph_d = take ? PH_SETUP : PH_EMPTY;
      default:   ph_d = PH_EMPTY;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) ph_q <= PH_EMPTY;
    else     ph_q <= ph_d;
  end
endmodule

// File: rtl/hrfw_pad_regs.sv
module hrfw_pad_regs #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         fire,
  input  logic [W-1:0] din,
  output logic [W-1:0] bus_q,
  output logic         wr_n_q
);
  // output flops sit right at the pins; no logic after them
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_q  <= '0;
      wr_n_q <= 1'b1;
    end else begin
      if (load) bus_q <= din;
      wr_n_q <= !fire;
    end
  end
endmodule

// File: rtl/hrfw_half_rate_writer.sv
module hrfw_half_rate_writer #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              space_n,
  output logic [DATA_W-1:0] bus_data,
  output logic              wr_n
);
  logic take, fire;

  hrfw_phase_ctl u_ctl (
    .clk       (clk),
    .rst       (rst),
    .src_valid (in_valid),
    .space_n   (space_n),
    .src_ready (in_ready),
    .take      (take),
    .fire      (fire)
  );

  hrfw_pad_regs #(.W(DATA_W)) u_pads (
    .clk    (clk),
    .rst    (rst),
    .load   (take),
    .fire   (fire),
    .din    (in_data),
    .bus_q  (bus_data),
    .wr_n_q (wr_n)
  );
endmodule

// File: rtl/hrfw_checker.sv
module hrfw_checker #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         in_ready,
  input logic         space_n,
  input logic [W-1:0] bus_data,
  input logic         wr_n
);
  assert_no_back_to_back_R2: assert property (@(posedge clk) disable iff (rst)
    !wr_n |=> wr_n);

  assert_bus_settled_R3: assert property (@(posedge clk) disable iff (rst)
    !wr_n |-> $stable(bus_data));

  assert_strobe_needs_room_R4: assert property (@(posedge clk) disable iff (rst)
    !wr_n |-> $past(!space_n));

  assert_full_holds_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_n && !in_ready && space_n) |=> (wr_n && !in_ready && $stable(bus_data)));

  assert_ready_in_strobe_R6: assert property (@(posedge clk) disable iff (rst)
    !wr_n |-> in_ready);

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_n && in_ready) |=> wr_n);
endmodule

bind hrfw_half_rate_writer hrfw_checker #(.W(DATA_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_ready (in_ready),
  .space_n  (space_n),
  .bus_data (bus_data),
  .wr_n     (wr_n)
);

// File: tb/tb_hrfw_half_rate_writer.sv
module tb_hrfw_half_rate_writer;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] in_data = '0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic         space_n = 1'b0;
  logic [W-1:0] bus_data;
  logic         wr_n;

  always #5 clk = ~clk;

  hrfw_half_rate_writer #(.DATA_W(W)) dut (.*);

  int checks = 0, fails = 0;
  bit done = 0;
  int p_valid = 0, p_room = 100;
  bit hold = 0;
  bit have_prev = 0;
  logic p_wr_n, p_ready, p_space;
  logic [W-1:0] p_bus;
  logic [W-1:0] sent_q[$];
  logic [W-1:0] cap_q[$];
  logic [W-1:0] last_sent;

  function automatic int exp_strobes(input int cycles);
    return cycles / 2;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    if (!wr_n) cap_q.push_back(bus_data);
    if (have_prev) begin
      if (!p_wr_n) chk(wr_n == 1'b1, "R2 strobe twice in a row", wr_n, 1);
      if (!wr_n) begin
        chk(bus_data == p_bus, "R3 bus moved into strobe", bus_data, p_bus);
        chk(p_space == 1'b0, "R4 strobe without room", p_space, 0);
        chk(in_ready == 1'b1, "R6 ready in strobe cycle", in_ready, 1);
      end
      if (p_wr_n && !p_ready && p_space) begin
        chk(wr_n == 1'b1, "R5 strobe while full", wr_n, 1);
        chk(in_ready == 1'b0, "R5/R6 ready while waiting", in_ready, 0);
        chk(bus_data == p_bus, "R5 bus changed while full", bus_data, p_bus);
      end
      if (p_wr_n && p_ready) chk(wr_n == 1'b1, "R9 strobe with nothing held", wr_n, 1);
    end
    p_wr_n = wr_n; p_ready = in_ready; p_bus = bus_data;
    // producer: keep a refused byte, otherwise draw a new one
    if (!hold) begin
      in_valid = (($urandom % 100) < p_valid);
      in_data  = W'($urandom);
    end
    if (in_valid && in_ready) begin
      sent_q.push_back(in_data);
      last_sent = in_data;
      hold = 0;
    end else begin
      hold = in_valid;
    end
    space_n = !(($urandom % 100) < p_room);
    p_space = space_n;
    have_prev = 1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int n;
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    chk(wr_n == 1'b1 && in_ready == 1'b1 && bus_data == '0, "R1 reset state",
        {wr_n, in_ready, bus_data}, {2'b11, 8'h00});
    rst = 1'b0;
    p_valid = 0; p_room = 100;
    repeat (4) step();
    chk(wr_n == 1'b1 && in_ready == 1'b1, "R1 state after reset", {wr_n, in_ready}, 3);

    // R10: latency from acceptance to strobe
    p_valid = 100;
    step();
    p_valid = 0;
    step();
    chk(wr_n == 1'b1 && in_ready == 1'b0, "R10 setup cycle", {wr_n, in_ready}, 2);
    chk(bus_data == last_sent, "R10 byte on bus", bus_data, last_sent);
    step();
    chk(wr_n == 1'b0, "R10 strobe follows", wr_n, 0);
    repeat (4) step();

    // R8: streaming at full rate
    p_valid = 100; p_room = 100;
    repeat (6) step();
    n = 0;
    for (int i = 0; i < 40; i++) begin
      step();
      if (!wr_n) n++;
    end
    chk(n == exp_strobes(40), "R8 strobe count", n, exp_strobes(40));

    // R5: far side full while bytes keep coming
    p_room = 0;
    n = 0;
    for (int i = 0; i < 12; i++) begin
      step();
      if (!wr_n && i > 0) n++;
    end
    chk(n == 0, "R5 no strobe while full", n, 0);
    p_room = 100;
    repeat (6) step();

    // random mixes
    p_valid = 70; p_room = 60;
    repeat (4000) step();
    p_valid = 95; p_room = 90;
    repeat (2000) step();
    p_valid = 30; p_room = 20;
    repeat (2000) step();

    // drain, then R9 idle check
    p_valid = 0; p_room = 100;
    while (hold) step();
    repeat (8) step();
    n = 0;
    for (int i = 0; i < 10; i++) begin
      step();
      if (!wr_n) n++;
    end
    chk(n == 0, "R9 idle stays quiet", n, 0);

    // R7: order and count
    chk(cap_q.size() == sent_q.size(), "R7 byte count", cap_q.size(), sent_q.size());
    for (int i = 0; i < sent_q.size() && i < cap_q.size(); i++)
      if (cap_q[i] != sent_q[i]) chk(0, "R7 byte order", cap_q[i], sent_q[i]);
    chk(1, "R7 order scan", 0, 0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule